// File: doc/BRIEF.md
# Self-Calibrating Serial Byte Receiver

This block receives asynchronous serial bytes without being told the line rate in advance. After reset it waits for a calibration character. It counts how many clock cycles the start bit of that character stays low, and it keeps that count as the bit period for all later traffic. The first data bit of the calibration character must be a 1, so the low time equals exactly one bit time. The character 0x55 satisfies this. The calibration frame itself is consumed silently. It produces no byte, no strobe and no error.

Once calibrated, the receiver waits for a falling edge on the idle-high line. It checks the start bit at its midpoint and then samples each following bit one full period later. The line carries eight data bits with the least significant bit first, then an optional even-parity bit, then a stop bit. A good frame presents the byte together with a one-cycle strobe. A bad parity bit or a low stop bit produces a one-cycle error pulse instead. The serial input is resynchronised through a two-stage flip-flop chain before any edge detection. The measured period is available as an output. It stays fixed until the next reset.

Top module: `selfbaud_rx`

## Requirements
- R1: While reset is held and right after it is released, `rxValid`, `parityErr` and `frameErr` are 0, and `bitPeriod` reads 0 (uncalibrated).
- R2: The first start bit after reset that lasts at least 4 cycles is timed in clock cycles, and `bitPeriod` takes that count. The first data bit of this frame must be 1. The whole frame raises no strobe and no error pulse.
- R3: A calibration low time of fewer than 4 cycles is discarded. `bitPeriod` stays 0 and the receiver keeps waiting for a calibration start bit. A nonzero `bitPeriod` is never below 4.
- R4: After calibration, a frame is sampled at bit centres. Bit 0 of `rxData` is the first data bit after the start bit, and `rxData` changes only in a cycle where `rxValid` is 1.
- R5: `rxValid` is high for exactly one cycle per frame, and only for a frame whose stop bit samples high and whose parity, when enabled, is correct.
- R6: A stop bit that samples low raises `frameErr` for one cycle, drops the byte without raising `rxValid`, and takes precedence over a parity error in the same frame.
- R7: With `parityEn` = 1 at the start edge, a parity bit follows the eighth data bit. The eight data bits plus the parity bit must hold an even number of ones. Otherwise `parityErr` pulses for one cycle in place of `rxValid`.
- R8: With `parityEn` = 0 at the start edge, the bit after the eighth data bit is the stop bit. A following frame may start right at the end of that stop bit.
- R9: A low level on the line that has ended by the start bit's midpoint (half the bit period after the falling edge) is taken as noise. It produces no output, and the next real frame is received normally.
- R10: At most one of `rxValid`, `parityErr` and `frameErr` is high in any cycle.
- R11: Once `bitPeriod` is nonzero it does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial line, idles high, asynchronous to clk |
| parityEn | input | 1 | 1: frames carry an even-parity bit; sampled at each start edge |
| rxData | output | 8 | Last byte received with a good stop bit and good parity |
| rxValid | output | 1 | One-cycle strobe when `rxData` holds a new byte |
| parityErr | output | 1 | One-cycle pulse when a frame's parity check fails |
| frameErr | output | 1 | One-cycle pulse when a stop bit samples low |
| bitPeriod | output | 16 | Measured clock cycles per bit; 0 until calibrated |

## Verification
The bound checker watches the output-side rules on every cycle. It checks that the three result outputs are mutually exclusive, that each is a single-cycle pulse, that the byte changes only alongside its strobe, and that a captured period never drops below the minimum or changes afterwards. What the byte value is, and whether a frame gives a byte, a parity error, a framing error or nothing, depends on the serial waveform. Only the bench's directed scenarios can show that. They cover calibration at two rates, a too-short calibration pulse, a noise pulse, back-to-back frames, a low stop bit, and good and bad parity.

// File: rtl/selfbaud_pkg.sv
`timescale 1ns/1ps
package selfbaud_pkg;

  typedef enum logic [2:0] {
    ST_CAL_WAIT,
    ST_CAL_MEAS,
    ST_CAL_SKIP,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_t;

  // Control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic timerLoad;    // restart the bit timer at 1
    logic capPeriod;    // store the timer as the bit period
    logic shiftIn;      // shift the line level into the byte
    logic clrFrame;     // clear parity accumulator and error
    logic chkParity;    // compare received parity bit
    logic emitValid;    // present the byte
    logic emitParErr;   // pulse parity error
    logic emitFrameErr; // pulse framing error
  } strobe_t;

endpackage

// File: rtl/selfbaud_dp.sv
`timescale 1ns/1ps
module selfbaud_dp
  import selfbaud_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8,
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  strobe_t              stb,
  output logic                 rxLevel,
  output logic                 fallEdge,
  output logic                 atHalf,
  output logic                 atFull,
  output logic                 tooShort,
  output logic                 parityBad,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 validOut,
  output logic                 parErrOut,
  output logic                 frameErrOut,
  output logic [CNT_W-1:0]     periodOut
);

  localparam logic [CNT_W-1:0] TIMER_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(MIN_PERIOD);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxPrev;
  logic [CNT_W-1:0]       timer;
  logic [DATA_BITS-1:0]   shiftReg;
  logic                   parAcc;

  // Resynchronise the asynchronous line, reset to idle level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      rxPrev    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxIn};
      rxPrev    <= syncChain[SYNC_STAGES-1];
    end
  end

  assign rxLevel  = syncChain[SYNC_STAGES-1];
  assign fallEdge = rxPrev & ~rxLevel;

  // Bit timer: holds cycles since last load, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (stb.timerLoad) begin
      timer <= CNT_W'(1);
    end else if (timer != TIMER_MAX) begin
      timer <= timer + CNT_W'(1);
    end
  end

  assign atHalf   = (timer == (periodOut >> 1));
  assign atFull   = (timer == periodOut);
  assign tooShort = (timer < MIN_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodOut <= '0;
    end else if (stb.capPeriod) begin
      periodOut <= timer;
    end
  end

  // Byte assembly and parity accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parAcc    <= 1'b0;
      parityBad <= 1'b0;
    end else begin
      if (stb.clrFrame) begin
        parAcc    <= 1'b0;
        parityBad <= 1'b0;
      end else begin
        if (stb.shiftIn) begin
          shiftReg <= {rxLevel, shiftReg[DATA_BITS-1:1]};
          parAcc   <= parAcc ^ rxLevel;
        end
        if (stb.chkParity) begin
          parityBad <= parAcc ^ rxLevel;
        end
      end
    end
  end

  // Registered results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut     <= '0;
      validOut    <= 1'b0;
      parErrOut   <= 1'b0;
      frameErrOut <= 1'b0;
    end else begin
      validOut    <= stb.emitValid;
      parErrOut   <= stb.emitParErr;
      frameErrOut <= stb.emitFrameErr;
      if (stb.emitValid) begin
        dataOut <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/selfbaud_ctrl.sv
`timescale 1ns/1ps
module selfbaud_ctrl
  import selfbaud_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    parityEn,
  input  logic    rxLevel,
  input  logic    fallEdge,
  input  logic    atHalf,
  input  logic    atFull,
  input  logic    tooShort,
  input  logic    parityBad,
  output strobe_t stb
);

  localparam int BC_W = $clog2(DATA_BITS + 1);
  localparam logic [BC_W-1:0] LAST_DATA = BC_W'(DATA_BITS - 1);
  localparam logic [BC_W-1:0] LAST_PAR  = BC_W'(DATA_BITS);

  rx_state_t       state, nextState;
  logic [BC_W-1:0] bitCnt, nextBitCnt;
  logic            parEnLat;
  logic            startSeen;
  logic [BC_W-1:0] lastSkip;

  assign startSeen = fallEdge && ((state == ST_IDLE) || (state == ST_CAL_WAIT));
  assign lastSkip  = parEnLat ? LAST_PAR : LAST_DATA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CAL_WAIT;
      bitCnt   <= '0;
      parEnLat <= 1'b0;
    end else begin
      state  <= nextState;
      bitCnt <= nextBitCnt;
      if (startSeen) begin
        parEnLat <= parityEn;
      end
    end
  end

  always_comb begin
    nextState  = state;
    nextBitCnt = bitCnt;
    stb        = '0;
    unique case (state)
      ST_CAL_WAIT: begin
        if (fallEdge) begin
          stb.timerLoad = 1'b1;
          nextState     = ST_CAL_MEAS;
        end
      end
      ST_CAL_MEAS: begin
        if (rxLevel) begin
          if (tooShort) begin
            nextState = ST_CAL_WAIT;
          end else begin
            stb.capPeriod = 1'b1;
            stb.timerLoad = 1'b1;
            nextBitCnt    = '0;
            nextState     = ST_CAL_SKIP;
          end
        end
      end
      ST_CAL_SKIP: begin
        // Let the rest of the calibration frame pass unread
        if (atFull) begin
          stb.timerLoad = 1'b1;
          if (bitCnt == lastSkip) begin
            nextState = ST_IDLE;
          end else begin
            nextBitCnt = bitCnt + BC_W'(1);
          end
        end
      end
      ST_IDLE: begin
        if (fallEdge) begin
          stb.timerLoad = 1'b1;
          nextState     = ST_START;
        end
      end
      ST_START: begin
        if (atHalf) begin
          if (rxLevel) begin
            nextState = ST_IDLE;
          end else begin
            stb.timerLoad = 1'b1;
            stb.clrFrame  = 1'b1;
            nextBitCnt    = '0;
            nextState     = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (atFull) begin
          stb.shiftIn   = 1'b1;
          stb.timerLoad = 1'b1;
          if (bitCnt == LAST_DATA) begin
            nextState = parEnLat ? ST_PARITY : ST_STOP;
          end else begin
            nextBitCnt = bitCnt + BC_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (atFull) begin
          stb.chkParity = 1'b1;
          stb.timerLoad = 1'b1;
          nextState     = ST_STOP;
        end
      end
      ST_STOP: begin
        if (atFull) begin
          if (!rxLevel) begin
            stb.emitFrameErr = 1'b1;
          end else if (parEnLat && parityBad) begin
            stb.emitParErr = 1'b1;
          end else begin
            stb.emitValid = 1'b1;
          end
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_CAL_WAIT;
    endcase
  end

endmodule

// File: rtl/selfbaud_rx.sv
`timescale 1ns/1ps
module selfbaud_rx
  import selfbaud_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8,
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 parityEn,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic [CNT_W-1:0]     bitPeriod
);

  strobe_t stb;
  logic    rxLevel, fallEdge, atHalf, atFull, tooShort, parityBad;

  selfbaud_ctrl #(
    .DATA_BITS (DATA_BITS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .parityEn  (parityEn),
    .rxLevel   (rxLevel),
    .fallEdge  (fallEdge),
    .atHalf    (atHalf),
    .atFull    (atFull),
    .tooShort  (tooShort),
    .parityBad (parityBad),
    .stb       (stb)
  );

  selfbaud_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_BITS   (DATA_BITS),
    .CNT_W       (CNT_W),
    .MIN_PERIOD  (MIN_PERIOD)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxIn        (rxIn),
    .stb         (stb),
    .rxLevel     (rxLevel),
    .fallEdge    (fallEdge),
    .atHalf      (atHalf),
    .atFull      (atFull),
    .tooShort    (tooShort),
    .parityBad   (parityBad),
    .dataOut     (rxData),
    .validOut    (rxValid),
    .parErrOut   (parityErr),
    .frameErrOut (frameErr),
    .periodOut   (bitPeriod)
  );

endmodule

// File: rtl/selfbaud_checker.sv
`timescale 1ns/1ps
module selfbaud_checker #(
  parameter int DATA_BITS  = 8,
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxValid,
  input logic                 parityErr,
  input logic                 frameErr,
  input logic [CNT_W-1:0]     bitPeriod
);

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, parityErr, frameErr}));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_frame_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  assert_parity_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr);

  assert_data_with_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxData != $past(rxData)) |-> rxValid);

  assert_period_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bitPeriod == '0) || (bitPeriod >= CNT_W'(MIN_PERIOD)));

  assert_period_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bitPeriod != '0) |=> $stable(bitPeriod));

endmodule

bind selfbaud_rx selfbaud_checker #(
  .DATA_BITS  (DATA_BITS),
  .CNT_W      (CNT_W),
  .MIN_PERIOD (MIN_PERIOD)
) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .rxData    (rxData),
  .rxValid   (rxValid),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .bitPeriod (bitPeriod)
);

// File: tb/selfbaud_rx_tb_top.sv
`timescale 1ns/1ps
module selfbaud_rx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic        parityEn = 1'b0;
  logic [7:0]  rxData;
  logic        rxValid, parityErr, frameErr;
  logic [15:0] bitPeriod;

  int checks = 0;
  int errors = 0;
  int bitLen = 16;
  bit done = 0;

  // Output monitor counters
  int   validCnt = 0, parCnt = 0, frameCnt = 0;
  int   widthBad = 0, multiHot = 0;
  logic [7:0] hist [0:31];
  logic prevV = 0, prevP = 0, prevF = 0;

  always #2.5 clk = ~clk;

  selfbaud_rx dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .parityEn(parityEn),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .frameErr(frameErr), .bitPeriod(bitPeriod)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        hist[validCnt % 32] = rxData;
        validCnt++;
      end
      if (parityErr) parCnt++;
      if (frameErr) frameCnt++;
      if ((rxValid && prevV) || (parityErr && prevP) || (frameErr && prevF)) widthBad++;
      if (32'(rxValid) + 32'(parityErr) + 32'(frameErr) > 1) multiHot++;
      prevV = rxValid; prevP = parityErr; prevF = frameErr;
    end else begin
      prevV = 0; prevP = 0; prevF = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rxIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit withPar,
                            input bit parBit, input bit stopBit);
    drive(1'b0, bitLen);
    for (int i = 0; i < 8; i++) drive(b[i], bitLen);
    if (withPar) drive(parBit, bitLen);
    drive(stopBit, bitLen);
    rxIn = 1'b1;
  endtask

  task automatic do_reset();
    rstN = 1'b0; rxIn = 1'b1; parityEn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(rxValid == 0 && parityErr == 0 && frameErr == 0, "R1", "result outputs after reset",
        int'(rxValid) + int'(parityErr) + int'(frameErr), 0);
    chk(bitPeriod == 0, "R1", "bitPeriod after reset", int'(bitPeriod), 0);
  endtask

  task automatic t_short_cal();
    drive(1'b0, 2);
    drive(1'b1, 20);
    chk(bitPeriod == 0, "R3", "short calibration pulse discarded", int'(bitPeriod), 0);
  endtask

  task automatic t_calibrate(input int len);
    int v0 = validCnt, e0 = parCnt + frameCnt;
    bitLen = len;
    send_frame(8'h55, 0, 0, 1);
    drive(1'b1, 4);
    chk(bitPeriod == 16'(len), "R2", "measured bit period", int'(bitPeriod), len);
    chk(validCnt == v0, "R2", "calibration frame gives no strobe", validCnt - v0, 0);
    chk(parCnt + frameCnt == e0, "R2", "calibration frame gives no error", parCnt + frameCnt - e0, 0);
  endtask

  task automatic t_byte(input logic [7:0] b, input string req);
    int v0 = validCnt;
    send_frame(b, 0, 0, 1);
    drive(1'b1, 2);
    chk(validCnt == v0 + 1, req, "one strobe per frame", validCnt - v0, 1);
    chk(hist[v0 % 32] == b, req, "received byte", int'(hist[v0 % 32]), int'(b));
  endtask

  task automatic t_back_to_back();
    int v0 = validCnt;
    send_frame(8'h12, 0, 0, 1);
    send_frame(8'h34, 0, 0, 1);
    drive(1'b1, 2);
    chk(validCnt == v0 + 2, "R8", "two adjacent frames", validCnt - v0, 2);
    chk(hist[v0 % 32] == 8'h12, "R8", "first adjacent byte", int'(hist[v0 % 32]), 'h12);
    chk(hist[(v0 + 1) % 32] == 8'h34, "R8", "second adjacent byte", int'(hist[(v0 + 1) % 32]), 'h34);
  endtask

  task automatic t_framing();
    int v0 = validCnt, f0 = frameCnt;
    send_frame(8'h5A, 0, 0, 0);
    drive(1'b1, 2 * bitLen);
    chk(frameCnt == f0 + 1, "R6", "framing error pulse", frameCnt - f0, 1);
    chk(validCnt == v0, "R6", "byte dropped on low stop", validCnt - v0, 0);
  endtask

  task automatic t_parity();
    int v0, p0, f0;
    parityEn = 1'b1;
    v0 = validCnt; p0 = parCnt;
    send_frame(8'h3C, 1, 0, 1);
    drive(1'b1, 2);
    chk(validCnt == v0 + 1 && hist[v0 % 32] == 8'h3C, "R7", "good parity 0x3C accepted",
        int'(hist[v0 % 32]), 'h3C);
    send_frame(8'h07, 1, 1, 1);
    drive(1'b1, 2);
    chk(validCnt == v0 + 2 && hist[(v0 + 1) % 32] == 8'h07, "R7", "good parity 0x07 accepted",
        int'(hist[(v0 + 1) % 32]), 'h07);
    chk(parCnt == p0, "R7", "no parity error on good frames", parCnt - p0, 0);
    send_frame(8'h07, 1, 0, 1);
    drive(1'b1, 2);
    chk(parCnt == p0 + 1, "R7", "bad parity pulses error", parCnt - p0, 1);
    chk(validCnt == v0 + 2, "R5", "no strobe on bad parity", validCnt - v0, 2);
    f0 = frameCnt; p0 = parCnt;
    send_frame(8'h07, 1, 0, 0);
    drive(1'b1, 2 * bitLen);
    chk(frameCnt == f0 + 1 && parCnt == p0, "R6", "framing error wins over parity",
        (frameCnt - f0) * 10 + (parCnt - p0), 10);
    parityEn = 1'b0;
  endtask

  task automatic t_false_start();
    int v0 = validCnt, e0 = parCnt + frameCnt;
    drive(1'b0, 3);
    drive(1'b1, 2 * bitLen);
    chk(validCnt == v0 && parCnt + frameCnt == e0, "R9", "noise pulse ignored",
        validCnt - v0 + parCnt + frameCnt - e0, 0);
    t_byte(8'h81, "R9");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_short_cal();
    t_calibrate(16);
    t_byte(8'hA5, "R4");
    t_byte(8'h3C, "R4");
    t_byte(8'hFF, "R4");
    t_byte(8'h00, "R4");
    t_back_to_back();
    t_framing();
    t_parity();
    t_false_start();
    chk(bitPeriod == 16, "R11", "period held after traffic", int'(bitPeriod), 16);
    do_reset();
    t_reset_state();
    t_calibrate(23);
    t_byte(8'hC3, "R4");
    chk(widthBad == 0, "R5", "result pulses one cycle wide", widthBad, 0);
    chk(multiHot == 0, "R10", "results mutually exclusive", multiHot, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule